// File: doc/BRIEF.md
# Command/Response Buffer Status Engine

This block is the device side of a byte-wide command channel. A host talks to it through two registers: a status register and a data FIFO port. Both are decoded inside one locality window of the address space. A host first writes the command-ready bit to claim an empty buffer. It then streams command bytes into the FIFO port and writes the go bit. After that it polls the status register until a response is flagged as available, and then drains the response through the same FIFO port.

Every command begins with a 10-byte header. The engine reads the total length from header bytes 2 to 5, taken as a big-endian 32-bit value. It uses that length to decide when the data-expect flag clears and what burst count to report. A stub executor stands in for real command processing. After a fixed latency it forms the response from the command: the command is echoed, except that bytes 6 to 9 (the result code) are forced to zero.

The engine moves through five states: idle, ready, receiving, executing and holding a response. A command-ready write returns it to the ready state from any state and discards any command or response it holds.

Top module: `cmdbuf_status_engine`

## Requirements
- R1: After reset the engine is idle. The status byte reads 0x80 (valid set, all flags clear) and both burst count bytes read 0.
- R2: The status byte has this layout: bit 7 is valid, bit 6 is command-ready, bit 5 is go (always reads 0), bit 4 is data-available, bit 3 is data-expect, and bits 2..0 are 0. Writing a status byte with bit 6 set moves the engine to ready, where the status reads 0xC8 and the burst count equals DEPTH.
- R3: The 16-bit burst count reads at status offset +1 (low byte) and +2 (high byte). The value depends on the state:
  - In ready, and in receiving before the length is known, it is DEPTH minus the bytes received.
  - In receiving once the length is known, it is the length minus the bytes received.
  - While holding a response, it is the length minus the bytes read.
  - In every other state it is 0.
- R4: The length is taken big-endian from header bytes 2..5, with byte 2 most significant. Data-expect stays set until the byte that brings the received count to that length has been written, and clears in the next cycle.
- R5: If the length formed at byte 5 is below 10 or above DEPTH, the command is discarded and the engine returns to ready (status 0xC8, burst count DEPTH).
- R6: A FIFO write that arrives when data-expect is clear is dropped. This covers idle, executing, holding a response, and a command that is already complete. The stored bytes and counts are not changed, and `fifo_drop` is high for exactly the next cycle.
- R7: A go write (status bit 5 set) moves a complete command to executing. Data-available rises exactly LATENCY cycles after the go write. A go write in any other state is ignored.
- R8: Response byte i equals command byte i, except that bytes 6..9 read 0. Each FIFO read while data is available returns the next byte and advances the read position.
- R9: Once the last response byte has been read, data-available is clear and further FIFO reads return 0xFF.
- R10: Valid (status bit 7) reads 0 in the cycle after any FIFO read or write. Otherwise it reads 1.
- R11: A command-ready write aborts from any state, including receiving and executing. No response appears afterwards.
- R12: The engine decodes the status register at offset 0x018 and the FIFO port at offset 0x024, and only when addr[15:12] equals LOC. Accesses to any other locality are ignored, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe; a FIFO read pops on the clock edge |
| addr | input | AW | Byte address: locality in bits 15:12, register offset in bits 11:0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and the current state |
| fifo_drop | output | 1 | One-cycle pulse after a FIFO write was dropped |

## Verification
Read data is combinational, so a register value belongs to the state reached at the last edge. A FIFO pop, a state change or a drop becomes visible one cycle after the access. The valid bit is low only in that cycle. The bench drives each access at a falling edge and samples a short delay later. It therefore reads status one cycle after every byte it writes, and treats bit 7 separately from the flag bits. Data-available is checked exactly LATENCY-1 and LATENCY cycles after the go write, which pins the latency of the executor. The sweep covers every legal length in a 16-byte configuration, plus lengths just outside the legal range and one with a nonzero top byte.

// File: rtl/cmdbuf_status_engine.sv
module cmdbuf_status_engine #(
  parameter int DEPTH   = 64,
  parameter int LATENCY = 8,
  parameter int LOC     = 0,
  parameter int AW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          fifo_drop
);
  localparam int HDR = 10;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = $clog2(DEPTH);
  localparam int LW  = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  typedef enum logic [2:0] {S_IDLE, S_READY, S_RECV, S_EXEC, S_RESP} st_t;

  st_t           state;
  logic [CW-1:0] cnt, rptr, len;
  logic          len_ok, touched;
  logic [23:0]   hdr;
  logic [LW-1:0] ecnt;
  logic [7:0]    mem [DEPTH];

  logic hit_loc, sel_sts, sel_b0, sel_b1, sel_fifo;
  logic fifo_wr, fifo_rd, sts_wr, accept, expect_f, avail_f, bad_len, go_ok;
  logic [31:0] full_len;
  logic [15:0] burst;
  logic [7:0]  sts, resp_byte;

  assign hit_loc  = addr[AW-1:12] == (AW-12)'(LOC);
  assign sel_sts  = hit_loc && addr[11:0] == 12'h018;
  assign sel_b0   = hit_loc && addr[11:0] == 12'h019;
  assign sel_b1   = hit_loc && addr[11:0] == 12'h01A;
  assign sel_fifo = hit_loc && addr[11:0] == 12'h024;

  assign fifo_wr = wr_en && sel_fifo;
  assign fifo_rd = rd_en && sel_fifo;
  assign sts_wr  = wr_en && sel_sts;

  assign expect_f = (state == S_READY) || (state == S_RECV && (!len_ok || cnt != len));
  assign accept   = expect_f;
  assign avail_f  = (state == S_RESP) && (rptr != len);
  assign full_len = {hdr, wdata};
  assign bad_len  = (full_len < 32'(HDR)) || (full_len > 32'(DEPTH));
  assign go_ok    = (state == S_RECV) && len_ok && (cnt == len);

  always_comb begin
    case (state)
      S_READY: burst = 16'(DEPTH);
      S_RECV:  burst = len_ok ? 16'(len - cnt) : 16'(CW'(DEPTH) - cnt);
      S_RESP:  burst = 16'(len - rptr);
      default: burst = 16'd0;
    endcase
  end

  assign sts = {~touched, state == S_READY, 1'b0, avail_f, expect_f, 3'b000};

  assign resp_byte = (rptr >= CW'(6) && rptr < CW'(HDR)) ? 8'h00 : mem[rptr[PW-1:0]];

  always_comb begin
    if (sel_sts)                  rdata = sts;
    else if (sel_b0)              rdata = burst[7:0];
    else if (sel_b1)              rdata = burst[15:8];
    else if (sel_fifo && avail_f) rdata = resp_byte;
    else                          rdata = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (fifo_wr && accept) mem[cnt[PW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      rptr      <= '0;
      len       <= '0;
      len_ok    <= 1'b0;
      hdr       <= '0;
      ecnt      <= '0;
      touched   <= 1'b0;
      fifo_drop <= 1'b0;
    end else begin
      touched   <= fifo_wr || fifo_rd;
      fifo_drop <= fifo_wr && !accept;
      if (sts_wr && wdata[6]) begin
        state  <= S_READY;
        cnt    <= '0;
        rptr   <= '0;
        len_ok <= 1'b0;
      end else begin
        case (state)
          S_READY, S_RECV: begin
            if (fifo_wr && accept) begin
              cnt   <= cnt + 1'b1;
              state <= S_RECV;
              if (cnt >= CW'(2) && cnt <= CW'(4)) hdr <= {hdr[15:0], wdata};
              if (cnt == CW'(5)) begin
                if (bad_len) begin
                  state <= S_READY;
                  cnt   <= '0;
                end else begin
                  len_ok <= 1'b1;
                  len    <= full_len[CW-1:0];
                end
              end
            end else if (sts_wr && wdata[5] && go_ok) begin
              state <= S_EXEC;
              ecnt  <= LW'(LATENCY - 1);
              rptr  <= '0;
            end
          end
          S_EXEC: begin
            if (ecnt == '0) state <= S_RESP;
            else            ecnt  <= ecnt - 1'b1;
          end
          S_RESP: begin
            if (fifo_rd && avail_f) rptr <= rptr + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdbuf_status_engine_chk.sv
module cmdbuf_status_engine_chk #(
  parameter int LOC = 0,
  parameter int AW  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic [7:0]    sts,
  input logic [15:0]   burst,
  input logic          fifo_drop
);
  logic at_sts, at_fifo;
  assign at_sts  = addr == {(AW-12)'(LOC), 12'h018};
  assign at_fifo = addr == {(AW-12)'(LOC), 12'h024};

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts[4] && sts[3])); // R4
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && at_fifo) |=> !sts[7]); // R10
  AST_AVAIL_HAS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    sts[4] |-> burst != 16'd0); // R3
  AST_ABORT_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_sts && wdata[6]) |=> (sts[6] && sts[3] && !sts[4])); // R11
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_fifo && !sts[3]) |=> fifo_drop); // R6
  AST_GO_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_sts && wdata[5] && !wdata[6] && !sts[4]) |=> !sts[4]); // R7
endmodule

bind cmdbuf_status_engine cmdbuf_status_engine_chk #(.LOC(LOC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .sts(sts), .burst(burst), .fifo_drop(fifo_drop)
);

// File: tb/cmdbuf_status_engine_test.sv
module cmdbuf_status_engine_test;
  localparam int DEPTH = 16;
  localparam int LAT   = 3;
  localparam int LOC   = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, fifo_drop;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  int total = 0, bad = 0, cyc = 0;
  logic [7:0] cmd [DEPTH];

  always #4 clk = ~clk;

  cmdbuf_status_engine #(.DEPTH(DEPTH), .LATENCY(LAT), .LOC(LOC), .AW(16)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fifo_drop(fifo_drop));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] off, input logic [7:0] d, input int loc = LOC);
    addr = {4'(loc), off}; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] off, output logic [7:0] d, input int loc = LOC);
    addr = {4'(loc), off}; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_sts(input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(12'h018, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic expect_burst(input int exp, input string req);
    logic [7:0] v;
    rd(12'h019, v);
    chk(v == 8'(exp), req, v, exp);
  endtask

  task automatic send_cmd(input int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      wr(12'h024, cmd[i]);
      rd(12'h018, v);
      chk((v & 8'h7F) == (((i + 1) < n) ? 8'h08 : 8'h00), "R4 data-expect", v & 8'h7F,
          ((i + 1) < n) ? 8'h08 : 8'h00);
      chk(v[7] == 1'b0, "R10 valid low after fifo write", v[7], 0);
      expect_burst((i < 5) ? DEPTH - (i + 1) : n - (i + 1), "R3 burst while receiving");
    end
  endtask

  task automatic build(input int n, input logic [31:0] lf);
    for (int i = 0; i < DEPTH; i++) cmd[i] = 8'((n * 7 + i * 13) & 8'hFF);
    cmd[0] = 8'h00; cmd[1] = 8'hC1;
    cmd[2] = lf[31:24]; cmd[3] = lf[23:16]; cmd[4] = lf[15:8]; cmd[5] = lf[7:0];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_sts(8'h80, "R1 reset status");
    expect_burst(0, "R1 reset burst");
    rd(12'h01A, v); chk(v == 8'h00, "R1 reset burst high", v, 0);

    wr(12'h018, 8'h40, LOC + 1);
    expect_sts(8'h80, "R12 other locality ignored");
    rd(12'h018, v, LOC + 1); chk(v == 8'hFF, "R12 other locality reads", v, 8'hFF);

    wr(12'h024, 8'h55);
    chk(fifo_drop == 1'b1, "R6 drop in idle", fifo_drop, 1);
    expect_sts(8'h00, "R10 valid low after dropped write");
    chk(fifo_drop == 1'b0, "R6 drop pulse one cycle", fifo_drop, 0);
    expect_sts(8'h80, "R6 idle write no effect");

    wr(12'h018, 8'h40);
    expect_sts(8'hC8, "R2 ready status");
    expect_burst(DEPTH, "R2 ready burst");
    wr(12'h018, 8'h20);
    expect_sts(8'hC8, "R7 go ignored in ready");

    for (int n = 10; n <= DEPTH; n++) begin
      wr(12'h018, 8'h40);
      build(n, 32'(n));
      send_cmd(n);
      wr(12'h024, 8'hAA);
      chk(fifo_drop == 1'b1, "R6 drop beyond length", fifo_drop, 1);
      expect_burst(0, "R6 burst unchanged after drop");
      wr(12'h018, 8'h20);
      repeat (LAT - 1) @(negedge clk);
      expect_sts(8'h80, "R7 not available before latency");
      expect_sts(8'h90, "R7 available at latency");
      expect_burst(n, "R3 burst holding response");
      for (int i = 0; i < n; i++) begin
        rd(12'h024, v);
        chk(v == ((i >= 6 && i < 10) ? 8'h00 : cmd[i]), "R8 response byte", v,
            (i >= 6 && i < 10) ? 8'h00 : cmd[i]);
      end
      expect_sts(8'h00, "R9 avail clear after last read");
      expect_sts(8'h80, "R10 valid returns");
      rd(12'h024, v); chk(v == 8'hFF, "R9 empty read", v, 8'hFF);
    end

    for (int k = 0; k < 3; k++) begin
      logic [31:0] lf;
      lf = (k == 0) ? 32'd9 : (k == 1) ? 32'(DEPTH + 1) : 32'h0100_000C;
      wr(12'h018, 8'h40);
      build(12, lf);
      for (int i = 0; i < 6; i++) wr(12'h024, cmd[i]);
      @(negedge clk);
      expect_sts(8'hC8, "R5 bad length aborts");
      expect_burst(DEPTH, "R5 burst after bad length");
    end

    wr(12'h018, 8'h40);
    build(12, 32'd12);
    for (int i = 0; i < 3; i++) wr(12'h024, cmd[i]);
    wr(12'h018, 8'h40);
    expect_sts(8'hC8, "R11 abort while receiving");
    expect_burst(DEPTH, "R11 burst after abort");

    send_cmd(12);
    wr(12'h018, 8'h20);
    wr(12'h018, 8'h40);
    expect_sts(8'hC8, "R11 abort while executing");
    repeat (LAT + 2) @(negedge clk);
    expect_sts(8'hC8, "R11 no response after abort");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule